// File: doc/BRIEF.md
# Dual Table-Driven Baud Generator

This block derives two independent 16x clock enables, one for a UART receiver and one for its transmitter, from a single 5.0688 MHz reference clock. Software picks a rate for each direction by writing one byte to a single bus address. The low nibble is the receive rate code and the high nibble is the transmit rate code. Each 4-bit code selects a divisor from a fixed 16-entry table. A per-channel down counter is reloaded from that divisor and produces one single-cycle enable pulse per period.

A build-time option halves every divisor, rounding down, so the block can drive a UART that samples at 32x the baud rate. After reset both channels run at code 0, which is 50 baud at 16x. A new code is picked up only when a counter reloads. The period already running therefore always finishes at its old length, and no short pulse appears.

Top module: `dual_baud_gen`

## Requirements
- R1: A write with `bus_wr` high and `bus_addr` equal to `REG_ADDR` stores `bus_wdata[3:0]` as the receive code and `bus_wdata[7:4]` as the transmit code, both in the same clock edge.
- R2: A write to any other address leaves both codes unchanged, so both tick periods stay as they were.
- R3: While reset is held both tick outputs are low. After reset both channels use code 0, so their period is 6336 cycles (3168 in half mode).
- R4: With `HALF_RATE`=0, codes 0 through 15 give tick periods of 6336, 4224, 2880, 2355, 2112, 1056, 528, 264, 176, 158, 132, 88, 66, 44, 33 and 16 reference cycles.
- R5: Each tick is high for exactly one cycle and is never high on two consecutive cycles.
- R6: A code change takes effect at the next reload. The period in progress completes at the old divisor, and the period that follows uses the new one.
- R7: The receive and transmit channels count independently, and each follows only its own nibble.
- R8: With `HALF_RATE`=1, every period is the R4 value divided by 2 and rounded down (for example code 3 gives 1177).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 5.0688 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 2*CODE_W | Write data: receive code in the low nibble, transmit code in the high nibble |
| rx_tick | output | 1 | Receive 16x (or 32x) clock enable |
| tx_tick | output | 1 | Transmit 16x (or 32x) clock enable |

## Verification
A write is registered on the edge at which it is presented. Its code is used at the next edge on which the counter sits at zero. The first tick seen after the write therefore closes the old period, and the gap to the second tick equals the new divisor. The bench drives inputs one time unit after a rising edge and counts ticks on falling edges. For every write it waits for that first tick, checks the interval ending there where the old length matters (R6), and then compares the following interval with the expected divisor. Every code is swept on both channels and in both divisor modes at once, with the receive and transmit codes always different.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   localparam int unsigned BG_CODE_W  = 4;
   localparam int unsigned BG_CODES   = 1 << BG_CODE_W;
   localparam int unsigned BG_MAX_DIV = 6336;
   localparam int unsigned BG_NUM_CH  = 2;

   typedef enum int unsigned {
      BG_CH_RX = 0,
      BG_CH_TX = 1
   } bg_chan_e;

   // Fixed divisor set for a 5.0688 MHz reference, 16x sampling.
   function automatic int unsigned bg_base_div(input logic [BG_CODE_W-1:0] code);
      int unsigned d;
      case (code)
         4'd0:    d = 6336;
         4'd1:    d = 4224;
         4'd2:    d = 2880;
         4'd3:    d = 2355;
         4'd4:    d = 2112;
         4'd5:    d = 1056;
         4'd6:    d = 528;
         4'd7:    d = 264;
         4'd8:    d = 176;
         4'd9:    d = 158;
         4'd10:   d = 132;
         4'd11:   d = 88;
         4'd12:   d = 66;
         4'd13:   d = 44;
         4'd14:   d = 33;
         default: d = 16;
      endcase
      return d;
   endfunction

   // Divisor after the optional 32x halving (round down).
   function automatic int unsigned bg_scaled_div(input logic [BG_CODE_W-1:0] code,
                                                 input bit halve);
      int unsigned b;
      b = bg_base_div(code);
      return halve ? (b >> 1) : b;
   endfunction

endpackage

// File: rtl/baud_ctrl_reg.sv
module baud_ctrl_reg #(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned NUM_CH   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_CH*CODE_W-1:0]      wdata,
   output logic [NUM_CH-1:0][CODE_W-1:0] code_q
);

   logic sel_hit;

   assign sel_hit = wr_en && (addr == REG_ADDR);

   // One write loads every channel nibble together.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (sel_hit) begin
         code_q <= wdata;
      end
   end

endmodule

// File: rtl/baud_div_rom.sv
module baud_div_rom
   import baud_gen_pkg::*;
#(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned CNT_W     = 13,
   parameter bit          HALF_RATE = 1'b0
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  div
);

   generate
      if (HALF_RATE) begin : g_half
         always_comb div = CNT_W'(bg_base_div(code) >> 1);
      end else begin : g_full
         always_comb div = CNT_W'(bg_base_div(code));
      end
   endgenerate

endmodule

// File: rtl/baud_chan_counter.sv
module baud_chan_counter #(
   parameter int unsigned       CNT_W      = 13,
   parameter logic [CNT_W-1:0]  RESET_LOAD = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] div,
   output logic [CNT_W-1:0] cnt_q,
   output logic             tick
);

   assign tick = (cnt_q == '0);

   // Divisor is sampled only on the reload edge, so a period never gets cut short.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= RESET_LOAD;
      end else if (tick) begin
         cnt_q <= div - CNT_W'(1);
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen
   import baud_gen_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h2A,
   parameter int unsigned       CODE_W    = 4,
   parameter int unsigned       CNT_W     = 13,
   parameter bit                HALF_RATE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [2*CODE_W-1:0]   bus_wdata,
   output logic                  rx_tick,
   output logic                  tx_tick
);

   localparam int unsigned NUM_CH     = BG_NUM_CH;
   localparam int unsigned MIN_CNT_W  = $clog2(BG_MAX_DIV + 1);
   localparam logic [CNT_W-1:0] RESET_LOAD =
      CNT_W'(bg_scaled_div(BG_CODE_W'(0), HALF_RATE) - 1);

   generate
      if (CODE_W != BG_CODE_W) begin : g_bad_code_w
         $error("dual_baud_gen: CODE_W must equal the divisor table index width");
      end
      if (CNT_W < MIN_CNT_W) begin : g_bad_cnt_w
         $error("dual_baud_gen: CNT_W too narrow for the largest divisor");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("dual_baud_gen: ADDR_W must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0][CODE_W-1:0] chan_code;
   logic [NUM_CH-1:0][CNT_W-1:0]  chan_div;
   logic [NUM_CH-1:0][CNT_W-1:0]  chan_cnt;
   logic [NUM_CH-1:0]             chan_tick;

   baud_ctrl_reg #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .CODE_W   (CODE_W),
      .NUM_CH   (NUM_CH)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .code_q (chan_code)
   );

   generate
      for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
         baud_div_rom #(
            .CODE_W    (CODE_W),
            .CNT_W     (CNT_W),
            .HALF_RATE (HALF_RATE)
         ) u_rom (
            .code (chan_code[gi]),
            .div  (chan_div[gi])
         );

         baud_chan_counter #(
            .CNT_W      (CNT_W),
            .RESET_LOAD (RESET_LOAD)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .div   (chan_div[gi]),
            .cnt_q (chan_cnt[gi]),
            .tick  (chan_tick[gi])
         );
      end
   endgenerate

   assign rx_tick = chan_tick[int'(BG_CH_RX)];
   assign tx_tick = chan_tick[int'(BG_CH_TX)];

endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker #(
   parameter int unsigned       ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0,
   parameter int unsigned       CODE_W   = 4,
   parameter int unsigned       CNT_W    = 13,
   parameter int unsigned       NUM_CH   = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [NUM_CH*CODE_W-1:0]      bus_wdata,
   input logic [NUM_CH-1:0][CODE_W-1:0] code,
   input logic [NUM_CH-1:0][CNT_W-1:0]  div,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
   input logic [NUM_CH-1:0]             tick
);

   logic reg_hit;
   assign reg_hit = bus_wr && (bus_addr == REG_ADDR);

   for (genvar ci = 0; ci < NUM_CH; ci++) begin : g_chk
      AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         reg_hit |=> code[ci] == $past(bus_wdata[ci*CODE_W +: CODE_W])); // R1
      AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !reg_hit |=> $stable(code[ci])); // R2
      AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         tick[ci] |=> !tick[ci]); // R5
      AST_RELOAD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
         tick[ci] |=> cnt[ci] == $past(div[ci]) - CNT_W'(1)); // R6
      AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
         !tick[ci] |=> cnt[ci] == $past(cnt[ci]) - CNT_W'(1)); // R4
      AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
         div[ci] >= CNT_W'(2)); // R8
   end

endmodule

bind dual_baud_gen baud_gen_checker #(
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR),
   .CODE_W   (CODE_W),
   .CNT_W    (CNT_W),
   .NUM_CH   (2)
) u_baud_gen_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .code      (chan_code),
   .div       (chan_div),
   .cnt       (chan_cnt),
   .tick      (chan_tick)
);

// File: tb/dual_baud_gen_bench.sv
`timescale 1ns/1ps
module dual_baud_gen_bench;

   localparam logic [7:0] ADDR = 8'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic       n_rx, n_tx, h_rx, h_tx;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   dual_baud_gen #(.REG_ADDR(ADDR), .HALF_RATE(1'b0)) u_dual_baud_gen (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rx_tick(n_rx), .tx_tick(n_tx));

   dual_baud_gen #(.REG_ADDR(ADDR), .HALF_RATE(1'b1)) u_dual_baud_gen_half (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rx_tick(h_rx), .tx_tick(h_tx));

   // Channel index: 0 rx full, 1 tx full, 2 rx half, 3 tx half
   logic [3:0] tk;
   assign tk = {h_tx, h_rx, n_tx, n_rx};

   int since    [4];
   int last_gap [4];
   int tick_cnt [4];
   int double_hits = 0;
   logic [3:0] tk_prev = '0;

   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (!rst_n) begin
            since[i] = 0; last_gap[i] = 0; tick_cnt[i] = 0;
         end else if (tk[i]) begin
            last_gap[i] = since[i] + 1;
            since[i] = 0;
            tick_cnt[i] = tick_cnt[i] + 1;
            if (tk_prev[i]) double_hits = double_hits + 1;
         end else begin
            since[i] = since[i] + 1;
         end
      end
      tk_prev = rst_n ? tk : 4'b0;
   end

   function automatic int exp_div(input int code, input bit half);
      int d;
      case (code)
         0: d = 6336;  1: d = 4224;  2: d = 2880;  3: d = 2355;
         4: d = 2112;  5: d = 1056;  6: d = 528;   7: d = 264;
         8: d = 176;   9: d = 158;   10: d = 132;  11: d = 88;
         12: d = 66;   13: d = 44;   14: d = 33;   default: d = 16;
      endcase
      return half ? d / 2 : d;
   endfunction

   task automatic check(input int act, input int exp, input string req);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic measure(input int ch, output int ga, output int gb);
      int n0;
      n0 = tick_cnt[ch];
      wait (tick_cnt[ch] >= n0 + 1);
      ga = last_gap[ch];
      wait (tick_cnt[ch] >= n0 + 2);
      gb = last_gap[ch];
   endtask

   int ga [4];
   int gb [4];

   task automatic measure_all();
      fork
         measure(0, ga[0], gb[0]);
         measure(1, ga[1], gb[1]);
         measure(2, ga[2], gb[2]);
         measure(3, ga[3], gb[3]);
      join
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(int'(tk), 0, "R3 ticks low in reset");
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(int'(tk), 0, "R3 ticks low after reset");

      // R3: default code 0 on both channels
      measure_all();
      for (int i = 0; i < 4; i++) check(gb[i], exp_div(0, i >= 2), "R3 reset period");

      // R2: write elsewhere is ignored
      bus_write(ADDR + 8'h01, 8'hFF);
      measure_all();
      for (int i = 0; i < 4; i++) check(gb[i], exp_div(0, i >= 2), "R2 foreign address");

      // R1 R4 R7 R8: sweep every code, rx and tx different
      for (int k = 0; k < 16; k++) begin
         bus_write(ADDR, {4'(15 - k), 4'(k)});
         measure_all();
         check(gb[0], exp_div(k, 1'b0),      "R4 R1 rx code");
         check(gb[1], exp_div(15 - k, 1'b0), "R4 R7 tx code");
         check(gb[2], exp_div(k, 1'b1),      "R8 rx half");
         check(gb[3], exp_div(15 - k, 1'b1), "R8 R7 tx half");
      end

      // R6: change mid-period, old period completes then new applies
      bus_write(ADDR, 8'h77);
      measure_all();
      repeat (100) @(posedge clk);
      bus_write(ADDR, 8'hFF);
      measure_all();
      for (int i = 0; i < 4; i++) begin
         check(ga[i], exp_div(7, i >= 2),  "R6 old period kept");
         check(gb[i], exp_div(15, i >= 2), "R6 new period");
      end

      check(double_hits, 0, "R5 single-cycle tick");
      finish_run();
   end

endmodule